// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A synchronous true dual-port memory of 2048 bytes with two independent ports, called left and right. Each port has its own select, write, output-enable, address and data lines. Either port can read or write any location in any cycle. A read returns its data one clock after the request.

The two highest addresses can serve as mailboxes between the ports. A port sends a message by writing a byte to its partner's mailbox. The right port's mailbox is the top address (0x7FF), and the left port's mailbox is the one below it (0x7FE). That write drives the partner's interrupt line low. The partner clears the interrupt by touching its own mailbox with select and output enable both high. It can read the message in the same access, or it can write.

A configuration input turns the mailbox function on or off. When it is off, the two top locations behave as plain storage and the interrupt lines never change. All control inputs are active high. The interrupt outputs are active low.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: Each port can write any address (select=1, write=1). Each port can read any address (select=1, write=0), and the read data appears on its data output one clock after the request.
- R2: With the mailbox function enabled, a write by the right port to address 0x7FE drives l_irq_n low on the next clock edge.
- R3: With the mailbox function enabled, a write by the left port to address 0x7FF drives r_irq_n low on the next clock edge.
- R4: A port clears its own interrupt (output back to 1 on the next edge) by accessing its own mailbox address with select=1 and output enable=1, whether it reads or writes. The same access with output enable=0 does not clear it.
- R5: If the same interrupt is set and cleared in the same cycle, it ends up set (low).
- R6: A mailbox byte is ordinary data: reading it returns the byte the sender wrote.
- R7: With mbx_en=0, accesses to 0x7FE and 0x7FF never change either interrupt output, and those addresses store and return data like any other location.
- R8: A port with select=0 reads nothing, writes nothing, and neither sets nor clears any interrupt. Its read data output holds its previous value.
- R9: When both ports write the same address in the same cycle, the left port's byte is stored.
- R10: While reset is high, both interrupt outputs are 1 and both read data outputs are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mbx_en | input | 1 | Turns the mailbox interrupt function on |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_oe | input | 1 | Left port output enable, needed to clear its interrupt |
| l_addr | input | 11 | Left port address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data, one cycle latency |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_oe | input | 1 | Right port output enable, needed to clear its interrupt |
| r_addr | input | 11 | Right port address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data, one cycle latency |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench targets the following corner cases:
- A clear issued in the same cycle as a new set. A design that let the clear win would drop a message.
- A mailbox access made without output enable. A design that ignored output enable would clear the interrupt early.
- A write to a mailbox with the port deselected or with mbx_en off. A design that decoded the address alone would raise an interrupt that should not appear.
- Two writes to one address in the same cycle. A design with the wrong write priority would store the right port's byte.

Random traffic concentrated on the two mailbox addresses checks every output in every cycle against a bench model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic oe;
    } ctl_t;

    function automatic op_e op_of(ctl_t c);
        if (!c.sel)
            return OP_IDLE;
        return c.wr ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '0,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mbx_en,
    output logic              rd,
    output logic              wr,
    output logic              clr_own,
    output logic              set_peer
);
    op_e op;

    always_comb begin
        op       = op_of(ctl);
        rd       = (op == OP_READ);
        wr       = (op == OP_WRITE);
        set_peer = mbx_en && wr && (addr == PEER_BOX);
        clr_own  = mbx_en && ctl.sel && ctl.oe && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_n <= 1'b1;
        else if (set)
            irq_n <= 1'b0;
        else if (clr)
            irq_n <= 1'b1;
    end

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> !irq_n);
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> irq_n);
    a_r8_hold_flag: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_mem_core.sv
module mbx_mem_core #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wd,
    output logic [DATA_W-1:0] l_q,
    input  logic              r_rd,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wd,
    output logic [DATA_W-1:0] r_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Right write first, left second: on an address clash the left byte lands.
    always_ff @(posedge clk) begin
        if (r_wr)
            mem[r_addr] <= r_wd;
        if (l_wr)
            mem[l_addr] <= l_wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q <= '0;
            r_q <= '0;
        end else begin
            if (l_rd)
                l_q <= mem[l_addr];
            if (r_rd)
                r_q <= mem[r_addr];
        end
    end

    a_r8_left_hold: assert property (@(posedge clk) disable iff (rst)
        !l_rd |=> $stable(l_q));
    a_r8_right_hold: assert property (@(posedge clk) disable iff (rst)
        !r_rd |=> $stable(r_q));
endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mbx_en,
    input  logic              l_cs,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int NPORT = 2;
    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};

    ctl_t              ctl  [NPORT];
    logic [ADDR_W-1:0] addr [NPORT];
    logic [NPORT-1:0]  rd, wr, clr_own, set_peer, irq_n;

    always_comb begin
        ctl[0]  = '{sel: l_cs, wr: l_we, oe: l_oe};
        ctl[1]  = '{sel: r_cs, wr: r_we, oe: r_oe};
        addr[0] = l_addr;
        addr[1] = r_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (p == 0 ? BOX_L : BOX_R),
            .PEER_BOX(p == 0 ? BOX_R : BOX_L)
        ) dec_i (
            .ctl     (ctl[p]),
            .addr    (addr[p]),
            .mbx_en  (mbx_en),
            .rd      (rd[p]),
            .wr      (wr[p]),
            .clr_own (clr_own[p]),
            .set_peer(set_peer[p])
        );

        mbx_flag flag_i (
            .clk  (clk),
            .rst  (rst),
            .set  (set_peer[NPORT-1-p]),
            .clr  (clr_own[p]),
            .irq_n(irq_n[p])
        );
    end

    mbx_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) core_i (
        .clk   (clk),
        .rst   (rst),
        .l_rd  (rd[0]),
        .l_wr  (wr[0]),
        .l_addr(l_addr),
        .l_wd  (l_wdata),
        .l_q   (l_rdata),
        .r_rd  (rd[1]),
        .r_wr  (wr[1]),
        .r_addr(r_addr),
        .r_wd  (r_wdata),
        .r_q   (r_rdata)
    );

    assign l_irq_n = irq_n[0];
    assign r_irq_n = irq_n[1];

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));
    a_r7_disabled: assert property (@(posedge clk) disable iff (rst)
        !mbx_en |=> ($stable(l_irq_n) && $stable(r_irq_n)));
    a_r8_idle_ports: assert property (@(posedge clk) disable iff (rst)
        (!l_cs && !r_cs) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
    a_r2_left_set: assert property (@(posedge clk) disable iff (rst)
        (mbx_en && r_cs && r_we && r_addr == BOX_L) |=> !l_irq_n);
    a_r3_right_set: assert property (@(posedge clk) disable iff (rst)
        (mbx_en && l_cs && l_we && l_addr == BOX_R) |=> !r_irq_n);
endmodule

// File: tb/dual_port_mailbox_ram_tb_top.sv
module dual_port_mailbox_ram_tb_top;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] LBOX = 11'h7FE;
    localparam logic [AW-1:0] RBOX = 11'h7FF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mbx_en = 1'b1;
    logic l_cs = 0, l_we = 0, l_oe = 0, r_cs = 0, r_we = 0, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [DW-1:0] m [DEPTH];
    logic [DW-1:0] e_lr = '0, e_rr = '0;
    bit e_lf = 0, e_rf = 0;

    always #10 clk = ~clk;

    dual_port_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .mbx_en(mbx_en),
        .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit hits(logic en, logic cs, logic cond, logic [AW-1:0] a,
                                logic [AW-1:0] box);
        return en && cs && cond && (a == box);
    endfunction

    // One clock: predict from the requirements, step, compare all outputs.
    task automatic tick(input string tag);
        bit ls, lc, rs, rc;
        if (l_cs && !l_we) e_lr = m[l_addr];
        if (r_cs && !r_we) e_rr = m[r_addr];
        ls = hits(mbx_en, r_cs, r_we, r_addr, LBOX);
        lc = hits(mbx_en, l_cs, l_oe, l_addr, LBOX);
        rs = hits(mbx_en, l_cs, l_we, l_addr, RBOX);
        rc = hits(mbx_en, r_cs, r_oe, r_addr, RBOX);
        if (ls) e_lf = 1; else if (lc) e_lf = 0;
        if (rs) e_rf = 1; else if (rc) e_rf = 0;
        if (r_cs && r_we) m[r_addr] = r_wdata;
        if (l_cs && l_we) m[l_addr] = l_wdata;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "l_rdata", l_rdata, e_lr);
        chk(tag, "r_rdata", r_rdata, e_rr);
        chk(tag, "l_irq_n", {7'd0, l_irq_n}, {7'd0, !e_lf});
        chk(tag, "r_irq_n", {7'd0, r_irq_n}, {7'd0, !e_rf});
    endtask

    task automatic lport(input logic cs, input logic we, input logic oe,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_cs = cs; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
    endtask

    task automatic rport(input logic cs, input logic we, input logic oe,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_cs = cs; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        lport(0, 0, 0, '0, '0);
        rport(0, 0, 0, '0, '0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(1234);
        for (int i = 0; i < DEPTH; i++) m[i] = '0;

        // R10: reset state
        @(posedge clk);
        @(negedge clk);
        chk("R10", "l_rdata", l_rdata, '0);
        chk("R10", "r_rdata", r_rdata, '0);
        chk("R10", "l_irq_n", {7'd0, l_irq_n}, 8'd1);
        chk("R10", "r_irq_n", {7'd0, r_irq_n}, 8'd1);
        rst = 0;

        // R1 / R7: fill the whole array with mailboxes off, both ports at once
        mbx_en = 0;
        for (int i = 0; i < DEPTH / 2; i++) begin
            lport(1, 1, 1, AW'(2 * i), DW'(i * 7 + 3));
            rport(1, 1, 1, AW'(2 * i + 1), DW'(i * 13 + 5));
            tick("R1 R7 fill");
        end
        // R7: mailbox locations read back as data, flags untouched
        lport(1, 0, 1, LBOX, '0); rport(1, 0, 1, RBOX, '0);
        tick("R7");
        mbx_en = 1;

        // R2: right writes left mailbox
        idle(); rport(1, 1, 0, LBOX, 8'h5A); tick("R2");
        // R4: access without output enable does not clear
        idle(); lport(1, 0, 0, LBOX, '0); tick("R4 no oe");
        // R4 / R6: read with output enable clears and returns the message
        idle(); lport(1, 0, 1, LBOX, '0); tick("R4 R6");
        // R3: left writes right mailbox
        idle(); lport(1, 1, 0, RBOX, 8'h33); tick("R3");
        // R4: clear by writing own mailbox
        idle(); rport(1, 1, 1, RBOX, 8'hC4); tick("R4 write clear");
        idle(); lport(1, 0, 0, RBOX, '0); tick("R6 readback");
        // R5: set and clear in the same cycle
        idle(); rport(1, 1, 0, LBOX, 8'h11); tick("R5 setup");
        lport(1, 0, 1, LBOX, '0); rport(1, 1, 0, LBOX, 8'h22); tick("R5");
        idle(); lport(1, 0, 1, LBOX, '0); tick("R5 clear");
        // R8: deselected ports with mailbox addresses
        lport(0, 1, 1, RBOX, 8'hEE); rport(0, 1, 1, LBOX, 8'hDD); tick("R8");
        idle(); lport(1, 0, 0, RBOX, '0); rport(1, 0, 0, LBOX, '0); tick("R8 no write");
        // R7: disabled mailbox write raises nothing
        mbx_en = 0;
        idle(); rport(1, 1, 1, LBOX, 8'h99); lport(1, 1, 1, RBOX, 8'h98); tick("R7 no set");
        mbx_en = 1;
        // R9: same-address collision
        lport(1, 1, 0, 11'h123, 8'hA1); rport(1, 1, 0, 11'h123, 8'hB2); tick("R9");
        idle(); lport(1, 0, 0, 11'h123, '0); tick("R9 readback");
        chk("R9", "collision byte", l_rdata, 8'hA1);

        // R1..R8: random traffic biased toward the mailboxes
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] la, ra;
            la = ($urandom % 2) ? AW'(11'h7FE + ($urandom % 2)) : AW'($urandom);
            ra = ($urandom % 2) ? AW'(11'h7FE + ($urandom % 2)) : AW'($urandom);
            mbx_en = ($urandom % 8) != 0;
            lport(($urandom % 4) != 0, $urandom % 2, $urandom % 2, la, DW'($urandom));
            rport(($urandom % 4) != 0, $urandom % 2, $urandom % 2, ra, DW'($urandom));
            tick("R1 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule